// File: doc/BRIEF.md
# Fractional-Rate Tick Timer

This block is a free-running phase-style accumulator that produces periodic timing events. Each clock it adds a programmable step value to an accumulator of `ACC_W` bits, which wraps modulo 2^ACC_W. Every time an addition overflows the top bit, a registered active-low tick output goes low for one cycle. With step value S, the average tick rate is S / 2^ACC_W of the clock rate. The remainder left after each wrap is kept, so fractional rates come out correctly over time.

Two active-low controls change the step register and the accumulator. Both are captured in an input register stage before they take effect:

- The load control copies the step data bus into the step register.
- The restart control also loads the step register. In the same cycle it cuts the accumulator feedback, so the next accumulator value is the step value alone and that addition cannot produce a tick.

Writing the step register over a bus, and whatever consumes the tick, belong to the surrounding logic.

Top module: `frac_tick_timer`

## Requirements
- R1: Synchronous active-low reset clears the accumulator and step register to zero, makes both registered controls inactive and holds `tick_n` high. After reset, with no load or restart, `tick_n` never goes low.
- R2: `step_load_n` low at clock edge k registers the request. At edge k+1 the step register takes the value that `step_data` had at edge k.
- R3: `restart_n` low at edge k also loads the step register at edge k+1, from the value `step_data` had at edge k.
- R4: When `restart_n` was low at edge k, the accumulator at edge k+1 equals the step register value held before that edge. The previous accumulator contents are not added.
- R5: At each edge the accumulator adds the step register value to its own value, or to zero under R4. `tick_n` goes low for exactly the cycle after an addition whose carry out of bit ACC_W-1 is 1. It is high otherwise.
- R6: The accumulator wraps modulo 2^ACC_W and keeps the remainder. A step of S therefore gives floor(n·S / 2^ACC_W) ticks over n cycles from zero.
- R7: While both controls are high, changes on `step_data` have no effect on the step register, and so none on the tick pattern.
- R8: The cycle whose addition uses the zeroed feedback from R4 never produces a tick, even when the previous accumulator plus the step would have overflowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_data | input | ACC_W | Step value for the step register |
| step_load_n | input | 1 | Load step register, active low, registered before use |
| restart_n | input | 1 | Load step register and zero accumulator feedback, active low, registered before use |
| tick_n | output | 1 | Registered overflow tick, active low |

## Verification
The bench builds the block with `ACC_W` = 8 and `SEG_W` = 4. At that width a wrap happens within at most 256 cycles, so ticks at many step values, including fractional ratios, appear in a short run. Two adder segments mean the carry between segments carries the overflow decision, which a single-segment build would never exercise. Restarts are placed just before an accumulator that is about to overflow, so the cut feedback path is what decides whether a tick appears.

// File: rtl/frac_tick_timer_pkg.sv
// Package: shared types and defaults for the fractional tick timer.
// Assumes: controls are active low throughout the block.
package frac_tick_timer_pkg;

    // Registered control pair; both fields active low.
    typedef struct packed {
        logic load_n;
        logic restart_n;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{load_n: 1'b1, restart_n: 1'b1};

    localparam int DEF_ACC_W = 32;
    localparam int DEF_SEG_W = 8;

endpackage

// File: rtl/ftt_in_stage.sv
// Module: input capture stage. Registers the step data bus and the two
// active-low controls so that they act one cycle after being sampled.
// Assumes: synchronous active-low reset; controls reset to inactive.
module ftt_in_stage
    import frac_tick_timer_pkg::*;
#(
    parameter int ACC_W = DEF_ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] data_in,
    input  logic             load_n_in,
    input  logic             restart_n_in,
    output logic [ACC_W-1:0] data_q,
    output ctl_t             ctl_q
);

    // Capture controls and data on every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            ctl_q  <= CTL_IDLE;
        end else begin
            data_q          <= data_in;
            ctl_q.load_n    <= load_n_in;
            ctl_q.restart_n <= restart_n_in;
        end
    end

endmodule

// File: rtl/ftt_step_reg.sv
// Module: step register. Loads the captured data when either registered
// control is active, otherwise holds its value.
// Assumes: ctl fields are active low and already registered.
module ftt_step_reg
    import frac_tick_timer_pkg::*;
#(
    parameter int ACC_W = DEF_ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_t             ctl_q,
    input  logic [ACC_W-1:0] data_q,
    output logic [ACC_W-1:0] step_q
);

    logic load_en;

    // Either a plain load or a restart writes the step register.
    always_comb begin
        load_en = !ctl_q.load_n || !ctl_q.restart_n;
    end

    // Hold or load the step value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (load_en) begin
            step_q <= data_q;
        end
    end

endmodule

// File: rtl/ftt_seg_adder.sv
// Module: segmented ripple adder with a gated feedback operand.
// Splits the sum into SEG_W-bit slices chained by slice carries; the
// final slice carry is the overflow out of the top bit.
// Assumes: ACC_W is a multiple of SEG_W.
module ftt_seg_adder
    import frac_tick_timer_pkg::*;
#(
    parameter int ACC_W = DEF_ACC_W,
    parameter int SEG_W = DEF_SEG_W
) (
    input  logic             zero_fb,
    input  logic [ACC_W-1:0] fb_in,
    input  logic [ACC_W-1:0] step_in,
    output logic [ACC_W-1:0] sum_out,
    output logic             cout
);

    localparam int NSEG = ACC_W / SEG_W;

    logic [ACC_W-1:0] fb_gated;
    logic [NSEG:0]    seg_c;

    // Cut the feedback path during a restart.
    always_comb begin
        fb_gated = zero_fb ? '0 : fb_in;
    end

    assign seg_c[0] = 1'b0;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        // One slice of the sum with its carry into the next slice.
        assign {seg_c[g+1], sum_out[g*SEG_W +: SEG_W]} =
            {1'b0, fb_gated[g*SEG_W +: SEG_W]} +
            {1'b0, step_in[g*SEG_W +: SEG_W]} +
            {{SEG_W{1'b0}}, seg_c[g]};
    end

    assign cout = seg_c[NSEG];

endmodule

// File: rtl/frac_tick_timer.sv
// Module: fractional-rate tick timer top. Accumulates the step value every
// clock and issues a registered active-low tick after each overflow.
// Assumes: synchronous active-low reset; ACC_W multiple of SEG_W.
module frac_tick_timer
    import frac_tick_timer_pkg::*;
#(
    parameter int ACC_W = DEF_ACC_W,
    parameter int SEG_W = DEF_SEG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] step_data,
    input  logic             step_load_n,
    input  logic             restart_n,
    output logic             tick_n
);

    ctl_t             ctl_q;
    logic [ACC_W-1:0] data_q;
    logic [ACC_W-1:0] step_q;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum_next;
    logic             sum_cout;
    logic             load_q_n;
    logic             restart_q_n;

    ftt_in_stage #(.ACC_W(ACC_W)) u_in (
        .clk          (clk),
        .rst_n        (rst_n),
        .data_in      (step_data),
        .load_n_in    (step_load_n),
        .restart_n_in (restart_n),
        .data_q       (data_q),
        .ctl_q        (ctl_q)
    );

    ftt_step_reg #(.ACC_W(ACC_W)) u_step (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl_q  (ctl_q),
        .data_q (data_q),
        .step_q (step_q)
    );

    ftt_seg_adder #(.ACC_W(ACC_W), .SEG_W(SEG_W)) u_add (
        .zero_fb (!ctl_q.restart_n),
        .fb_in   (acc_q),
        .step_in (step_q),
        .sum_out (sum_next),
        .cout    (sum_cout)
    );

    // Flatten the control struct for observation.
    always_comb begin
        load_q_n    = ctl_q.load_n;
        restart_q_n = ctl_q.restart_n;
    end

    // Accumulator register, wrapping modulo 2^ACC_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= sum_next;
        end
    end

    // Registered active-low tick from the adder overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_n <= 1'b1;
        end else begin
            tick_n <= !sum_cout;
        end
    end

endmodule

// File: rtl/frac_tick_timer_chk.sv
// Module: assertion checker for frac_tick_timer, attached by bind.
// Assumes: observed signals are the top's internal registers.
module frac_tick_timer_chk #(
    parameter int ACC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_n,
    input logic             sum_cout,
    input logic             load_q_n,
    input logic             restart_q_n,
    input logic [ACC_W-1:0] data_q,
    input logic [ACC_W-1:0] step_q,
    input logic [ACC_W-1:0] acc_q
);

    // R1
    tick_idle_in_reset_chk: assert property (@(posedge clk)
        !rst_n |=> tick_n);

    // R2
    step_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_q_n |=> step_q == $past(data_q));

    // R3
    restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_q_n |=> step_q == $past(data_q));

    // R4
    restart_zero_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_q_n |=> acc_q == $past(step_q));

    // R5
    tick_from_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sum_cout |=> !tick_n);

    // R5
    no_tick_without_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sum_cout |=> tick_n);

    // R7
    step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_q_n && restart_q_n) |=> $stable(step_q));

    // R8
    restart_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_q_n |=> tick_n);

endmodule

bind frac_tick_timer frac_tick_timer_chk #(.ACC_W(ACC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_n      (tick_n),
    .sum_cout    (sum_cout),
    .load_q_n    (load_q_n),
    .restart_q_n (restart_q_n),
    .data_q      (data_q),
    .step_q      (step_q),
    .acc_q       (acc_q)
);

// File: tb/frac_tick_timer_bench.sv
// Bench: scoreboard for frac_tick_timer. The driver models each edge from
// the requirements and queues the expected tick; the monitor compares.
module frac_tick_timer_bench;

    localparam int W     = 8;
    localparam int SEG   = 4;
    localparam int LIMIT = 200000;

    typedef struct {
        logic  exp;
        string tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] step_data;
    logic         step_load_n;
    logic         restart_n;
    logic         tick_n;

    int   checks = 0;
    int   errors = 0;
    exp_t sb_q[$];
    exp_t item;

    // Requirement model state.
    logic [W-1:0] m_acc, m_step, m_data;
    logic         m_ld_n, m_rs_n;

    frac_tick_timer #(.ACC_W(W), .SEG_W(SEG)) u_frac_tick_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_data   (step_data),
        .step_load_n (step_load_n),
        .restart_n   (restart_n),
        .tick_n      (tick_n)
    );

    always #10 clk = ~clk;

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // One cycle: drive at the falling edge, model the next rising edge.
    task automatic step(input logic ld_n, input logic rs_n,
                        input logic [W-1:0] d, input string tag);
        logic [W:0] s;
        step_load_n = ld_n;
        restart_n   = rs_n;
        step_data   = d;
        s = {1'b0, (m_rs_n ? m_acc : '0)} + {1'b0, m_step};
        if (!m_ld_n || !m_rs_n) m_step = m_data;
        m_acc  = s[W-1:0];
        m_ld_n = ld_n;
        m_rs_n = rs_n;
        m_data = d;
        sb_q.push_back('{exp: !s[W], tag: tag});
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, 1'b1, W'(i * 37 + 5), tag);
    endtask

    // Monitor: compare the tick a quarter period after each rising edge.
    always @(posedge clk) begin
        #5;
        if (sb_q.size() > 0) begin
            item = sb_q.pop_front();
            checks++;
            if (tick_n !== item.exp) begin
                errors++;
                $display("FAIL %s: tick_n=%b expected %b at %0t",
                         item.tag, tick_n, item.exp, $time);
            end
        end
    end

    // Watchdog.
    initial begin
        #(20 * LIMIT);
        errors++;
        $display("FAIL watchdog: run did not end, actual running expected done");
        finish_up();
    end

    initial begin
        rst_n = 1'b0; step_load_n = 1'b1; restart_n = 1'b1; step_data = '0;
        m_acc = '0; m_step = '0; m_data = '0; m_ld_n = 1'b1; m_rs_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (tick_n !== 1'b1) begin
            errors++;
            $display("FAIL R1: tick_n=%b expected 1 in reset", tick_n);
        end
        rst_n = 1'b1;
        // R1, R7: no load, bus toggles, never a tick
        idle(20, "R1");
        // R2: step 0x40 gives a tick every 4 cycles
        step(1'b0, 1'b1, 8'h40, "R2");
        idle(16, "R2");
        // R7: bus changes without enable, pattern unchanged
        for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 8'hFF, "R7");
        // R6: fractional step 0x30 keeps the remainder
        step(1'b0, 1'b1, 8'h30, "R6");
        idle(40, "R6");
        // R3, R4: restart loads 0x80 and restarts from the old step
        step(1'b1, 1'b0, 8'h80, "R3");
        idle(8, "R4");
        // R8: restart when accumulator is about to overflow
        step(1'b0, 1'b1, 8'hF0, "R8");
        idle(3, "R8");
        step(1'b1, 1'b0, 8'hF0, "R8");
        idle(6, "R8");
        // R5: near-full step ticks almost every cycle, zero step never
        step(1'b0, 1'b1, 8'hFF, "R5");
        idle(12, "R5");
        step(1'b1, 1'b0, 8'h00, "R5");
        idle(12, "R5");
        // R5, R6: mixed random traffic
        for (int i = 0; i < 400; i++) begin
            logic [2:0] r;
            r = 3'($urandom);
            step(r != 3'd0, !(r == 3'd1 && i[0]), 8'($urandom), "R5");
        end
        idle(3, "R5");
        repeat (3) @(negedge clk);
        finish_up();
    end

endmodule